// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches one already-debounced pin level and turns it into a latched interrupt status, under the control of a small per-pin configuration word. The configuration selects edge or level sensing and the polarity: falling/low, rising/high, or either edge. A separate arm bit gates detection and a delivery bit gates the outgoing request. A wake-enable bit lets the same event also latch a wake status.

Software acknowledges the pin with a single-cycle write-one-to-clear strobe that drops both status flags. In level mode a still-present active level raises the status again on the following cycle. Rewriting the trigger type (sense mode or polarity) discards any pending status, so a stale event recorded under the old setting is never delivered. The block covers one pin; a chip instantiates one per pin and gathers the outputs elsewhere.

Top module: `gpio_irq_detect`

## Requirements
- R1: While `rst_n` is low, `irq_sts`, `wake_sts`, `irq_req` and `svc_req` are all 0.
- R2: With `cfg_level`=0, `cfg_pol` selects the edge: 2'b01 rising, 2'b00 falling, 2'b10 either. An edge is a change of `pin_lvl` between two consecutive clock edges, and it sets `irq_sts` at the clock edge that sees the new level.
- R3: With `cfg_level`=1, `cfg_pol`=2'b01 sets `irq_sts` on every clock edge where `pin_lvl` is 1, and `cfg_pol`=2'b00 does so where `pin_lvl` is 0. `cfg_pol`=2'b10 keeps its either-edge meaning whatever `cfg_level` is.
- R4: `cfg_pol`=2'b11 never sets `irq_sts` or `wake_sts`, in either sense mode.
- R5: With `cfg_en`=0 no event is latched, and a status already latched keeps its value.
- R6: `irq_req` is 1 exactly when `irq_sts` and `cfg_unmask` are both 1. `svc_req` is 1 when `irq_sts` or `wake_sts` is 1.
- R7: `sts_clr`=1 at a clock edge clears `irq_sts` and `wake_sts`. In edge sensing, an edge seen at that same clock edge survives the clear and leaves the status set.
- R8: In level sensing, a clear wins over the active level in its own cycle. If the level is still active, the status is set again at the next clock edge.
- R9: When `cfg_wake_en`=1, each event that sets `irq_sts` also sets `wake_sts`. With `cfg_wake_en`=0 no event sets `wake_sts`.
- R10: A clock edge at which {`cfg_level`,`cfg_pol`} differs from its value at the previous clock edge (taken as 3'b000 out of reset) clears both status flags, and any event seen at that edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 1 | Debounced pin level |
| cfg_en | input | 1 | Arms event detection |
| cfg_unmask | input | 1 | 1 lets a latched status drive the request |
| cfg_level | input | 1 | 1 level sensing, 0 edge sensing |
| cfg_pol | input | 2 | Polarity: 00 low/falling, 01 high/rising, 10 either edge, 11 reserved |
| cfg_wake_en | input | 1 | Lets events also latch the wake status |
| sts_clr | input | 1 | Write-one-to-clear strobe for both status flags |
| irq_sts | output | 1 | Latched interrupt status |
| wake_sts | output | 1 | Latched wake status |
| irq_req | output | 1 | Delivered interrupt request |
| svc_req | output | 1 | Pin needs service (either status set) |

## Verification
The clear strobe and a new event can land on the same clock edge. The outcome depends on the sense mode: an edge survives the clear, while an active level loses that cycle and returns one cycle later. Directed sequences drive an edge and the strobe together, and hold an active level across a strobe. The random phase raises the strobe a quarter of the time against random pin levels and occasional type rewrites. A cycle model written from the requirements predicts every output, including the case where a type rewrite coincides with an event.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Polarity / trigger selection code
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_BOTH = 2'b10,
    TRIG_RSVD = 2'b11
  } trig_sel_e;

  localparam int unsigned POL_W     = 2;
  localparam int unsigned TYPE_W    = POL_W + 1;
  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLAG_IRQ  = 0;
  localparam int unsigned FLAG_WAKE = 1;

endpackage

// File: rtl/gpio_pin_history.sv
module gpio_pin_history (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = pin_i;
    rise_o = pin_i & ~prev_q;
    fall_o = ~pin_i & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/gpio_trig_qual.sv
module gpio_trig_qual
  import gpio_irq_pkg::*;
(
  input  logic      en_i,
  input  logic      level_i,
  input  trig_sel_e sel_i,
  input  logic      pin_i,
  input  logic      rise_i,
  input  logic      fall_i,
  input  logic      type_chg_i,
  output logic      hit_o,
  output logic      lvl_sense_o
);
  logic raw;

  always_comb begin
    case (sel_i)
      TRIG_LOW:  raw = level_i ? ~pin_i : fall_i;
      TRIG_HIGH: raw = level_i ?  pin_i : rise_i;
      TRIG_BOTH: raw = rise_i | fall_i;
      default:   raw = 1'b0;
    endcase
    lvl_sense_o = level_i && (sel_i != TRIG_BOTH);
    hit_o       = en_i & raw & ~type_chg_i;
  end
endmodule

// File: rtl/gpio_sticky_flag.sv
module gpio_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic flush_i,
  input  logic clr_wins_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic upd;

  always_comb begin
    upd = set_i | clr_i | flush_i;
    if (flush_i) flag_d = 1'b0;
    else         flag_d = (flag_q & ~clr_i) | (set_i & ~(clr_i & clr_wins_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (upd) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_lvl,
  input  logic             cfg_en,
  input  logic             cfg_unmask,
  input  logic             cfg_level,
  input  logic [POL_W-1:0] cfg_pol,
  input  logic             cfg_wake_en,
  input  logic             sts_clr,
  output logic             irq_sts,
  output logic             wake_sts,
  output logic             irq_req,
  output logic             svc_req
);
  logic [TYPE_W-1:0]    type_q;
  logic [TYPE_W-1:0]    type_d;
  logic                 type_chg;
  logic                 rise, fall;
  logic                 hit, lvl_sense;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_q;

  always_comb begin
    type_d   = {cfg_level, cfg_pol};
    type_chg = (type_d != type_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        type_q <= '0;
    else if (type_chg) type_q <= type_d;
  end

  gpio_pin_history u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  gpio_trig_qual u_qual (
    .en_i        (cfg_en),
    .level_i     (cfg_level),
    .sel_i       (trig_sel_e'(cfg_pol)),
    .pin_i       (pin_lvl),
    .rise_i      (rise),
    .fall_i      (fall),
    .type_chg_i  (type_chg),
    .hit_o       (hit),
    .lvl_sense_o (lvl_sense)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_IRQ]  = hit;
    flag_set[FLAG_WAKE] = hit & cfg_wake_en;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    gpio_sticky_flag u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (flag_set[g]),
      .clr_i      (sts_clr),
      .flush_i    (type_chg),
      .clr_wins_i (lvl_sense),
      .flag_o     (flag_q[g])
    );
  end

  always_comb begin
    irq_sts  = flag_q[FLAG_IRQ];
    wake_sts = flag_q[FLAG_WAKE];
    irq_req  = flag_q[FLAG_IRQ] & cfg_unmask;
    svc_req  = |flag_q;
  end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_en,
  input logic       cfg_unmask,
  input logic       cfg_level,
  input logic [1:0] cfg_pol,
  input logic       cfg_wake_en,
  input logic       sts_clr,
  input logic       irq_sts,
  input logic       wake_sts,
  input logic       irq_req
);
  // R4: reserved polarity code never raises the status
  a_r4_rsvd_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pol == 2'b11 && !irq_sts) |=> !irq_sts);

  // R5: disarmed pin latches nothing new
  a_r5_disarmed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !irq_sts) |=> !irq_sts);

  // R6: request only with delivery enabled
  a_r6_req_needs_unmask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> cfg_unmask);

  // R8: clear beats an active level in its own cycle
  a_r8_level_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && cfg_level && cfg_pol != 2'b10) |=> !irq_sts);

  // R9: wake status rises only together with interrupt status
  a_r9_wake_with_sts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_sts) |-> irq_sts);

  // R9: no wake latch while wake is not enabled
  a_r9_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wake_en && !wake_sts) |=> !wake_sts);
endmodule

bind gpio_irq_detect gpio_irq_detect_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_en      (cfg_en),
  .cfg_unmask  (cfg_unmask),
  .cfg_level   (cfg_level),
  .cfg_pol     (cfg_pol),
  .cfg_wake_en (cfg_wake_en),
  .sts_clr     (sts_clr),
  .irq_sts     (irq_sts),
  .wake_sts    (wake_sts),
  .irq_req     (irq_req)
);

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin_lvl, cfg_en, cfg_unmask, cfg_level, cfg_wake_en, sts_clr;
  logic [1:0] cfg_pol;
  logic       irq_sts, wake_sts, irq_req, svc_req;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic       m_sts, m_wake, m_prev;
  logic [2:0] m_type;

  always #2.5 clk = ~clk;

  gpio_irq_detect uut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .cfg_en(cfg_en),
    .cfg_unmask(cfg_unmask), .cfg_level(cfg_level), .cfg_pol(cfg_pol),
    .cfg_wake_en(cfg_wake_en), .sts_clr(sts_clr), .irq_sts(irq_sts),
    .wake_sts(wake_sts), .irq_req(irq_req), .svc_req(svc_req)
  );

  function automatic logic raw_event(input logic lvl, input logic [1:0] pol,
                                     input logic pin, input logic prev);
    case (pol)
      2'b00:   return lvl ? ~pin : (prev & ~pin);
      2'b01:   return lvl ?  pin : (~prev & pin);
      2'b10:   return pin ^ prev;
      default: return 1'b0;
    endcase
  endfunction

  task automatic compare(input string tag);
    logic [3:0] got, exp;
    got = {irq_sts, wake_sts, irq_req, svc_req};
    exp = {m_sts, m_wake, m_sts & cfg_unmask, m_sts | m_wake};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {sts,wake,req,svc} got %b expected %b", tag, got, exp);
    end
  endtask

  // one clock: model updates at the edge, outputs checked at the falling edge
  task automatic tick(input string tag);
    logic chg, hit, lsense;
    @(posedge clk);
    chg    = ({cfg_level, cfg_pol} != m_type);
    lsense = cfg_level && (cfg_pol != 2'b10);
    hit    = cfg_en & raw_event(cfg_level, cfg_pol, pin_lvl, m_prev) & ~chg;
    if (chg) begin
      m_sts = 1'b0; m_wake = 1'b0;
    end else begin
      m_sts  = (m_sts  & ~sts_clr) | (hit & ~(sts_clr & lsense));
      m_wake = (m_wake & ~sts_clr) | (hit & cfg_wake_en & ~(sts_clr & lsense));
    end
    m_prev = pin_lvl;
    m_type = {cfg_level, cfg_pol};
    @(negedge clk);
    compare(tag);
  endtask

  task automatic set_type(input logic lvl, input logic [1:0] pol);
    cfg_level = lvl; cfg_pol = pol;
    tick("R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; pin_lvl = 0; cfg_en = 0; cfg_unmask = 0; cfg_level = 0;
    cfg_pol = 2'b00; cfg_wake_en = 0; sts_clr = 0;
    m_sts = 0; m_wake = 0; m_prev = 0; m_type = 3'b000;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;

    // R2 rising edge, then clear without a new edge (R7)
    cfg_en = 1; cfg_unmask = 1;
    set_type(1'b0, 2'b01);
    tick("R2");
    pin_lvl = 1; tick("R2");
    sts_clr = 1; tick("R7"); sts_clr = 0; tick("R7");
    // R2 falling edge
    set_type(1'b0, 2'b00);
    pin_lvl = 0; tick("R2");
    sts_clr = 1; tick("R7"); sts_clr = 0;
    // R2 either edge
    set_type(1'b0, 2'b10);
    pin_lvl = 1; tick("R2");
    sts_clr = 1; tick("R7"); sts_clr = 0;
    pin_lvl = 0; tick("R2");
    sts_clr = 1; tick("R7"); sts_clr = 0;
    // R4 reserved code, both sense modes
    set_type(1'b0, 2'b11);
    for (int i = 0; i < 4; i++) begin pin_lvl = ~pin_lvl; tick("R4"); end
    set_type(1'b1, 2'b11);
    for (int i = 0; i < 4; i++) begin pin_lvl = ~pin_lvl; tick("R4"); end
    // R3 level high, R8 clear beats level then re-asserts
    set_type(1'b1, 2'b01);
    pin_lvl = 1; tick("R3");
    sts_clr = 1; tick("R8"); sts_clr = 0; tick("R8");
    pin_lvl = 0; sts_clr = 1; tick("R8"); sts_clr = 0; tick("R3");
    // R3 level low
    set_type(1'b1, 2'b00);
    tick("R3");
    pin_lvl = 1; sts_clr = 1; tick("R8"); sts_clr = 0; tick("R3");
    // R7 edge and clear in the same cycle
    set_type(1'b0, 2'b01);
    pin_lvl = 0; tick("R7");
    pin_lvl = 1; sts_clr = 1; tick("R7"); sts_clr = 0;
    // R6 delivery mask
    cfg_unmask = 0; tick("R6"); cfg_unmask = 1; tick("R6");
    // R5 disarmed: status held, new edges ignored
    cfg_en = 0; pin_lvl = 0; tick("R5");
    sts_clr = 1; tick("R5"); sts_clr = 0;
    pin_lvl = 1; tick("R5"); pin_lvl = 0; tick("R5");
    cfg_en = 1;
    // R9 wake latch and shared clear
    cfg_wake_en = 1; pin_lvl = 1; tick("R9");
    sts_clr = 1; pin_lvl = 0; tick("R9"); sts_clr = 0;
    cfg_wake_en = 0; pin_lvl = 1; tick("R9");
    // R10 type change flushes status and swallows a same-cycle event
    cfg_wake_en = 1;
    cfg_level = 1; tick("R10"); tick("R10");
    cfg_pol = 2'b00; pin_lvl = 0; tick("R10"); tick("R10");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      pin_lvl     = 1'($urandom);
      sts_clr     = ($urandom % 4) == 0;
      cfg_en      = ($urandom % 8) != 0;
      cfg_unmask  = 1'($urandom);
      cfg_wake_en = 1'($urandom);
      if (($urandom % 16) == 0) begin
        cfg_level = 1'($urandom);
        cfg_pol   = 2'($urandom);
      end
      tick("random R2 R3 R7 R8 R9 R10");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule